// File: doc/BRIEF.md
# Half-to-Single Precision Float Widener

This block takes a 16-bit binary16 floating-point code and produces the 32-bit binary32 code with exactly the same value. Every half-precision value fits in single precision, so no rounding happens: each output is determined bit for bit by its input. Normal numbers get a rebiased exponent and a zero-extended fraction. Signed zeros and infinities keep their sign. NaNs come out quiet, with the rest of their payload moved up into the wider fraction. Subnormal halves become normal singles: a priority encoder finds the leading one of the mantissa, and the mantissa is shifted left by that amount.

A producer presents one code per cycle with a valid strobe. By default the result is registered, so the valid strobe and the data come out one cycle later. When the register option is turned off, the path is purely combinational. The block keeps no other state.

Top module: `fpw_top`

## Requirements
- R1: When the input exponent field (bits 14:10) is between 1 and 30, the output exponent (bits 30:23) equals the input exponent plus 112. Output bits 22:13 equal input bits 9:0, and output bits 12:0 are zero.
- R2: When input bits 14:0 are all zero, output bits 30:0 are all zero.
- R3: When the input exponent field is 31 and the mantissa (bits 9:0) is zero, the output exponent is 255 and the output fraction is zero.
- R4: When the input exponent field is 31 and the mantissa is non-zero, the output exponent is 255 and output bit 22 is 1. Output bits 21:13 equal input bits 8:0, and bits 12:0 are zero.
- R5: When the input exponent field is 0 and the mantissa is non-zero, let k be the number of zeros above the highest set mantissa bit (0 to 9). The output exponent is 112 minus k. Output bits 22:13 hold the mantissa shifted left by k+1 and truncated to 10 bits. Output bits 12:0 are zero.
- R6: Output bit 31 equals input bit 15 for every input code.
- R7: With the register option on (the default), the output valid in a cycle equals the input valid of the previous cycle, and the data follows with the same one-cycle latency.
- R8: With the register option on, the output data does not change across a clock edge at which the input valid is low.
- R9: While reset is asserted, the output valid is 0 and the output data is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Input code is present this cycle |
| halfIn | input | 16 | binary16 code |
| validOut | output | 1 | Output code is valid |
| singleOut | output | 32 | binary32 code |

## Verification
The assertions assume that halfIn is a defined, non-X value in every cycle that validIn is high. They also assume that reset is held for at least one clock edge before the first valid input. The stimulus changes inputs only at the falling clock edge and starts driving codes only after reset is released. It also drives a deliberately changed halfIn while validIn is low, so that the hold property is tested against data that would otherwise load.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  localparam int IN_EXP_W  = 5;
  localparam int IN_MAN_W  = 10;
  localparam int OUT_EXP_W = 8;
  localparam int OUT_MAN_W = 23;
  localparam int IN_W      = 1 + IN_EXP_W + IN_MAN_W;
  localparam int OUT_W     = 1 + OUT_EXP_W + OUT_MAN_W;
  localparam int IN_BIAS   = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS  = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int BIAS_DIFF = OUT_BIAS - IN_BIAS;
  localparam int PAD_W     = OUT_MAN_W - IN_MAN_W;
  localparam int LZ_W      = $clog2(IN_MAN_W);

  typedef struct packed {
    logic selNorm;
    logic selZero;
    logic selInf;
    logic selNan;
    logic selSub;
    logic loadEn;
  } cvtStrobes_t;
endpackage

// File: rtl/fpw_ctrl.sv
module fpw_ctrl
  import fpw_pkg::*;
(
  input  logic                validIn,
  input  logic [IN_EXP_W-1:0] expField,
  input  logic [IN_MAN_W-1:0] manField,
  output cvtStrobes_t         strobes
);
  logic expAllZero;
  logic expAllOne;
  logic manNonZero;

  always_comb begin
    expAllZero = (expField == '0);
    expAllOne  = (expField == '1);
    manNonZero = |manField;
    strobes.selZero = expAllZero && !manNonZero;
    strobes.selSub  = expAllZero && manNonZero;
    strobes.selInf  = expAllOne && !manNonZero;
    strobes.selNan  = expAllOne && manNonZero;
    strobes.selNorm = !expAllZero && !expAllOne;
    strobes.loadEn  = validIn;
  end
endmodule

// File: rtl/fpw_datapath.sv
module fpw_datapath
  import fpw_pkg::*;
(
  input  cvtStrobes_t         strobes,
  input  logic                signBit,
  input  logic [IN_EXP_W-1:0] expField,
  input  logic [IN_MAN_W-1:0] manField,
  output logic [OUT_W-1:0]    result
);
  logic [LZ_W-1:0]      leadZeros;
  logic [IN_MAN_W-1:0]  subFrac;
  logic [OUT_EXP_W-1:0] normExp;
  logic [OUT_EXP_W-1:0] subExp;
  logic [IN_MAN_W:0]    shifted;

  // Priority encoder: the highest set bit wins, since it is visited last.
  always_comb begin
    leadZeros = '0;
    for (int i = 0; i < IN_MAN_W; i++) begin
      if (manField[i]) leadZeros = LZ_W'(IN_MAN_W - 1 - i);
    end
  end

  always_comb begin
    shifted = {1'b0, manField} << (leadZeros + 1'b1);
    subFrac = shifted[IN_MAN_W-1:0];
    normExp = OUT_EXP_W'(expField) + OUT_EXP_W'(BIAS_DIFF);
    subExp  = OUT_EXP_W'(BIAS_DIFF) - OUT_EXP_W'(leadZeros);
  end

  always_comb begin
    result = {signBit, {(OUT_W-1){1'b0}}};
    unique case (1'b1)
      strobes.selNorm: result = {signBit, normExp, manField, {PAD_W{1'b0}}};
      strobes.selSub:  result = {signBit, subExp, subFrac, {PAD_W{1'b0}}};
      strobes.selInf:  result = {signBit, {OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}};
      strobes.selNan:  result = {signBit, {OUT_EXP_W{1'b1}}, 1'b1,
                                 manField[IN_MAN_W-2:0], {PAD_W{1'b0}}};
      default:         result = {signBit, {(OUT_W-1){1'b0}}};
    endcase
  end
endmodule

// File: rtl/fpw_top.sv
module fpw_top
  import fpw_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [IN_W-1:0]  halfIn,
  output logic             validOut,
  output logic [OUT_W-1:0] singleOut
);
  cvtStrobes_t      strobes;
  logic [OUT_W-1:0] convWord;

  fpw_ctrl u_ctrl (
    .validIn (validIn),
    .expField(halfIn[IN_W-2 -: IN_EXP_W]),
    .manField(halfIn[IN_MAN_W-1:0]),
    .strobes (strobes)
  );

  fpw_datapath u_dp (
    .strobes (strobes),
    .signBit (halfIn[IN_W-1]),
    .expField(halfIn[IN_W-2 -: IN_EXP_W]),
    .manField(halfIn[IN_MAN_W-1:0]),
    .result  (convWord)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic             validQ;
      logic [OUT_W-1:0] dataQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validQ <= 1'b0;
          dataQ  <= '0;
        end else begin
          validQ <= strobes.loadEn;
          if (strobes.loadEn) dataQ <= convWord;
        end
      end
      assign validOut  = validQ;
      assign singleOut = dataQ;
    end else begin : g_comb
      assign validOut  = strobes.loadEn;
      assign singleOut = convWord;
    end
  endgenerate
endmodule

// File: rtl/fpw_checker.sv
module fpw_checker
  import fpw_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             validIn,
  input logic [IN_W-1:0]  halfIn,
  input logic             validOut,
  input logic [OUT_W-1:0] singleOut
);
  logic inZero, inInf, inNan;
  assign inZero = (halfIn[IN_W-2:0] == '0);
  assign inInf  = (halfIn[IN_W-2 -: IN_EXP_W] == '1) && (halfIn[IN_MAN_W-1:0] == '0);
  assign inNan  = (halfIn[IN_W-2 -: IN_EXP_W] == '1) && (halfIn[IN_MAN_W-1:0] != '0);

  generate
    if (REG_OUT) begin : g_seq
      AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
        validIn |=> validOut);  // R7
      AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rstN)
        !validIn |=> !validOut);  // R7
      AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !validIn |=> $stable(singleOut));  // R8
      AST_SIGN_PASS: assert property (@(posedge clk) disable iff (!rstN)
        validIn |=> singleOut[OUT_W-1] == $past(halfIn[IN_W-1]));  // R6
      AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rstN)
        (validIn && inZero) |=> singleOut[OUT_W-2:0] == '0);  // R2
      AST_INF_MAP: assert property (@(posedge clk) disable iff (!rstN)
        (validIn && inInf) |=> singleOut[OUT_W-2:0] == {{OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}});  // R3
      AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
        (validIn && inNan) |=> singleOut[OUT_W-2 -: OUT_EXP_W+1] == '1);  // R4
    end else begin : g_cmb
      AST_SIGN_PASS: assert property (@(posedge clk) disable iff (!rstN)
        validIn |-> singleOut[OUT_W-1] == halfIn[IN_W-1]);  // R6
      AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rstN)
        (validIn && inZero) |-> singleOut[OUT_W-2:0] == '0);  // R2
      AST_INF_MAP: assert property (@(posedge clk) disable iff (!rstN)
        (validIn && inInf) |-> singleOut[OUT_W-2:0] == {{OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}});  // R3
      AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
        (validIn && inNan) |-> singleOut[OUT_W-2 -: OUT_EXP_W+1] == '1);  // R4
    end
  endgenerate
endmodule

bind fpw_top fpw_checker #(.REG_OUT(REG_OUT)) u_fpw_chk (
  .clk      (clk),
  .rstN     (rstN),
  .validIn  (validIn),
  .halfIn   (halfIn),
  .validOut (validOut),
  .singleOut(singleOut)
);

// File: tb/tb_fpw_top.sv
module tb_fpw_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [15:0] halfIn = '0;
  logic        validOut;
  logic [31:0] singleOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fpw_top dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .halfIn(halfIn),
    .validOut(validOut), .singleOut(singleOut)
  );

  // {input, expected output, requirement number}
  localparam logic [55:0] VEC [15] = '{
    {16'h3C00, 32'h3F800000, 8'd1},
    {16'hC000, 32'hC0000000, 8'd1},
    {16'h7BFF, 32'h477FE000, 8'd1},
    {16'h0400, 32'h38800000, 8'd1},
    {16'h3555, 32'h3EAAA000, 8'd1},
    {16'h0000, 32'h00000000, 8'd2},
    {16'h8000, 32'h80000000, 8'd2},
    {16'h7C00, 32'h7F800000, 8'd3},
    {16'hFC00, 32'hFF800000, 8'd3},
    {16'h7E00, 32'h7FC00000, 8'd4},
    {16'h7C01, 32'h7FC02000, 8'd4},
    {16'hFD00, 32'hFFE00000, 8'd4},
    {16'h0001, 32'h33800000, 8'd5},
    {16'h03FF, 32'h387FC000, 8'd5},
    {16'h8200, 32'hB8000000, 8'd5}
  };

  function automatic logic [31:0] refModel(input logic [15:0] h);
    logic       s = h[15];
    logic [4:0] e = h[14:10];
    logic [10:0] m = {1'b0, h[9:0]};
    int         ex;
    if (e == 5'd0 && m == 0) return {s, 31'd0};
    if (e == 5'd31) begin
      if (m == 0) return {s, 8'hFF, 23'd0};
      return {s, 8'hFF, 1'b1, m[8:0], 13'd0};
    end
    if (e != 5'd0) return {s, 8'(int'(e) + 112), m[9:0], 13'd0};
    ex = 113;
    while (m[10] == 1'b0) begin
      m = m << 1;
      ex = ex - 1;
    end
    return {s, 8'(ex), m[9:0], 13'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] lastOut;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 valid", {31'd0, validOut}, 32'd0);
    check("R9 data", singleOut, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Table of directed vectors, streamed back to back (R1..R5, R7)
    for (int i = 0; i < 15; i++) begin
      validIn = 1'b1;
      halfIn  = VEC[i][55:40];
      @(negedge clk);
      check("R7 valid", {31'd0, validOut}, 32'd1);
      check($sformatf("R%0d", VEC[i][7:0]), singleOut, VEC[i][39:8]);
    end

    // R8: changed data with valid low must not load
    lastOut = singleOut;
    validIn = 1'b0;
    halfIn  = 16'h4248;
    @(negedge clk);
    check("R7 valid low", {31'd0, validOut}, 32'd0);
    check("R8 hold", singleOut, lastOut);
    @(negedge clk);
    check("R8 hold again", singleOut, lastOut);

    // R6 and R1..R5: full sweep against the reference model
    for (int c = 0; c < 65536; c++) begin
      validIn = 1'b1;
      halfIn  = 16'(c);
      @(negedge clk);
      check("R6 sweep", singleOut, refModel(16'(c)));
    end
    validIn = 1'b0;
    @(negedge clk);

    // R9: reset asserted again mid-run clears outputs
    rstN = 1'b0;
    #1;
    check("R9 re-reset data", singleOut, 32'd0);
    check("R9 re-reset valid", {31'd0, validOut}, 32'd0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule